// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block turns a set of request lines into the binary number of the most urgent one. Every signal at its edge is active low. An eight-input stage compares its requests and reports the highest-numbered asserted line as an inverted three-bit number. It also drives two flags. One is a group-hit flag, which goes low when the stage found a request. The other is a pass-down enable, which goes low when the stage is enabled but idle.

The pass-down enable of one stage feeds the enable input of the stage below it. This lets stages chain into a wider encoder with no glue logic between them. The top level chains a parameterised number of stages, two by default, which gives a 16-to-4 encoder. The extra high code bits name the stage that holds the winning request. The low code bits are the AND of the stage codes. The combined group-hit flag is the AND of the stage flags. The whole path is combinational, and the outputs follow the inputs within the same cycle.

Top module: `prio_chain`

## Requirements
- R1: In a single stage, a high enable input forces all three code bits, the group-hit flag and the pass-down enable high, whatever the request lines carry.
- R2: In a single stage with enable low and all eight requests high, the code reads 3'b111, the group-hit flag is high and the pass-down enable is low.
- R3: In a single stage with enable low and at least one request low, the group-hit flag is low and the pass-down enable is high.
- R4: A single stage drives its code as the bitwise inverse of the index of the asserted request: request 7 alone gives 3'b000 and request 0 alone gives 3'b111.
- R5: Request 7 has the highest priority in a stage. When several requests are low, only the highest-numbered one sets the code, and the lower ones have no effect on it.
- R6: In the chained encoder, a high enable input forces all four code bits, the group-hit flag and the pass-down enable high.
- R7: In the chained encoder, the 4-bit code is the inverse of the index (0..15) of the highest-numbered low request. Bit 3 of the code is low exactly when one of requests 15..8 is low.
- R8: In the chained encoder with enable low, no request low gives code 4'b1111, group-hit high and pass-down low. Any request low gives group-hit low and pass-down high.
- R9: In the chained encoder, requests 7..0 have no effect on the code while any of requests 15..8 is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enInN | input | 1 | Enable for the whole chain, active low |
| reqN | input | 16 | Request lines, active low; bit 15 wins |
| codeN | output | 4 | Inverted index of the winning request |
| grpSelN | output | 1 | Low when any request is reported |
| enOutN | output | 1 | Low when enabled and no request is present; feeds a further chain |

## Verification
A stage that reports the wrong activity shows up at the ports at once. Either both flags are low together, or the code names an input that is not asserted. A fault in the enable chain shows as a lower stage that answers while an upper stage holds a request. That appears on the very vector that first asserts requests in both halves, because the low code bits are then corrupted by the AND. The bench applies every combination of enable and requests to one stage. It then drives the chain with corner and random patterns, and every result is compared in the same cycle in which it is applied.

// File: rtl/prio_pkg.sv
package prio_pkg;
  // Strobes from a stage's control part to its datapath part.
  typedef struct packed {
    logic active;  // stage enabled
    logic hit;     // stage enabled and some request asserted
  } prioStrobe_t;
endpackage

// File: rtl/prio8_ctrl.sv
module prio8_ctrl
  import prio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         enInN,
  input  logic [W-1:0] dataN,
  output prioStrobe_t  strobe,
  output logic         grpSelN,
  output logic         enOutN
);
  logic anyReq;

  always_comb begin
    anyReq        = ~&dataN;
    strobe.active = ~enInN;
    strobe.hit    = ~enInN & anyReq;
    grpSelN       = ~strobe.hit;
    enOutN        = ~(strobe.active & ~anyReq);
  end

  always_comb begin
    // R3
    one_flag_low_chk: assert (!(grpSelN == 1'b0 && enOutN == 1'b0))
      else $error("group-hit and pass-down both low");
  end
endmodule

// File: rtl/prio8_data.sv
module prio8_data
  import prio_pkg::*;
#(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  prioStrobe_t   strobe,
  input  logic [W-1:0]  dataN,
  output logic [CW-1:0] codeN
);
  logic [CW-1:0] winIdx;

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < W; i++) begin
      if (!dataN[i]) winIdx = CW'(i);
    end
    codeN = strobe.hit ? ~winIdx : '1;
  end

  always_comb begin
    // R4
    code_names_low_input_chk: assert (!strobe.hit || !dataN[~codeN])
      else $error("code names an input that is not asserted");
    // R5
    top_input_wins_chk: assert (!(strobe.hit && !dataN[W-1]) || codeN == '0)
      else $error("top input asserted but code not zero");
  end
endmodule

// File: rtl/prio8_stage.sv
module prio8_stage
  import prio_pkg::*;
#(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic          enInN,
  input  logic [W-1:0]  dataN,
  output logic [CW-1:0] codeN,
  output logic          grpSelN,
  output logic          enOutN
);
  prioStrobe_t strobe;

  prio8_ctrl #(.W(W)) u_ctrl (
    .enInN  (enInN),
    .dataN  (dataN),
    .strobe (strobe),
    .grpSelN(grpSelN),
    .enOutN (enOutN)
  );

  prio8_data #(.W(W)) u_data (
    .strobe(strobe),
    .dataN (dataN),
    .codeN (codeN)
  );

  always_comb begin
    // R1
    disabled_all_high_chk: assert (!enInN || (codeN == '1 && grpSelN && enOutN))
      else $error("disabled stage drives a low output");
  end
endmodule

// File: rtl/prio_chain.sv
module prio_chain #(
  parameter int STAGES = 2,
  parameter int SW_IN  = 8,
  localparam int CW    = $clog2(SW_IN),
  localparam int SELW  = $clog2(STAGES),
  localparam int NW    = STAGES * SW_IN
) (
  input  logic               enInN,
  input  logic [NW-1:0]      reqN,
  output logic [CW+SELW-1:0] codeN,
  output logic               grpSelN,
  output logic               enOutN
);
  logic [STAGES:0]   enChain;
  logic [STAGES-1:0] stageGsN;
  logic [CW-1:0]     stageCode [STAGES];
  logic [SELW-1:0]   selBin;
  logic [CW-1:0]     lowAnd;

  assign enChain[STAGES] = enInN;

  // Highest stage index has highest priority; its pass-down enables the next one below.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    prio8_stage #(.W(SW_IN)) u_stage (
      .enInN  (enChain[s+1]),
      .dataN  (reqN[s*SW_IN +: SW_IN]),
      .codeN  (stageCode[s]),
      .grpSelN(stageGsN[s]),
      .enOutN (enChain[s])
    );
  end

  always_comb begin
    selBin = '0;
    lowAnd = '1;
    for (int s = 0; s < STAGES; s++) begin
      if (!stageGsN[s]) selBin = SELW'(s);
      lowAnd = lowAnd & stageCode[s];
    end
    codeN   = {~selBin, lowAnd};
    grpSelN = &stageGsN;
    enOutN  = enChain[0];
  end

  always_comb begin
    // R9
    single_stage_hit_chk: assert ($countones(~stageGsN) <= 1)
      else $error("more than one stage reports a hit");
    // R6
    chain_disabled_chk: assert (!enInN || (codeN == '1 && grpSelN && enOutN))
      else $error("disabled chain drives a low output");
  end
endmodule

// File: tb/prio_chain_tb.sv
module prio_chain_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        enInN;
  logic [15:0] reqN;
  logic [3:0]  codeN;
  logic        grpSelN, enOutN;

  logic        sEnInN;
  logic [7:0]  sDataN;
  logic [2:0]  sCodeN;
  logic        sGsN, sEoN;

  prio_chain u_dut (
    .enInN(enInN), .reqN(reqN), .codeN(codeN), .grpSelN(grpSelN), .enOutN(enOutN)
  );

  prio8_stage u_stage (
    .enInN(sEnInN), .dataN(sDataN), .codeN(sCodeN), .grpSelN(sGsN), .enOutN(sEoN)
  );

  // {code, gs, eo}
  function automatic logic [4:0] refStage(logic ei, logic [7:0] d);
    int idx = -1;
    if (ei) return 5'b11111;
    for (int i = 0; i < 8; i++) if (!d[i]) idx = i;
    if (idx < 0) return {3'b111, 1'b1, 1'b0};
    return {~3'(idx), 1'b0, 1'b1};
  endfunction

  function automatic logic [5:0] refChain(logic ei, logic [15:0] d);
    int idx = -1;
    if (ei) return 6'b111111;
    for (int i = 0; i < 16; i++) if (!d[i]) idx = i;
    if (idx < 0) return {4'b1111, 1'b1, 1'b0};
    return {~4'(idx), 1'b0, 1'b1};
  endfunction

  task automatic checkStage(logic ei, logic [7:0] d);
    logic [4:0] exp, act;
    string tag;
    @(posedge clk);
    sEnInN = ei; sDataN = d;
    @(negedge clk);
    exp = refStage(ei, d);
    act = {sCodeN, sGsN, sEoN};
    if (ei) tag = "R1";
    else if (&d) tag = "R2";
    else if ($countones(~d) > 1) tag = "R3 R5";
    else tag = "R3 R4";
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s stage ei=%b d=%b actual=%b expected=%b", tag, ei, d, act, exp);
    end
  endtask

  task automatic checkChain(logic ei, logic [15:0] d);
    logic [5:0] exp, act;
    string tag;
    @(posedge clk);
    enInN = ei; reqN = d;
    @(negedge clk);
    exp = refChain(ei, d);
    act = {codeN, grpSelN, enOutN};
    if (ei) tag = "R6";
    else if (&d) tag = "R8";
    else if (!(&d[15:8]) && !(&d[7:0])) tag = "R9";
    else tag = "R7 R8";
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s chain ei=%b d=%h actual=%b expected=%b", tag, ei, d, act, exp);
    end
  endtask

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    enInN = 1'b1; reqN = '1; sEnInN = 1'b1; sDataN = '1;
    // exhaustive single stage: R1 R2 R3 R4 R5
    for (int v = 0; v < 512; v++) checkStage(v[8], v[7:0]);
    // chain corners
    checkChain(1'b1, 16'h0000);                          // R6
    checkChain(1'b0, 16'hFFFF);                          // R8
    for (int i = 0; i < 16; i++) checkChain(1'b0, ~(16'h1 << i));  // R7 single requests
    checkChain(1'b0, 16'h0000);                          // R9 all asserted
    checkChain(1'b0, 16'h7F00);                          // R9 top wins over low half
    checkChain(1'b0, 16'hFEFE);                          // R9 bit 8 over bit 0
    checkChain(1'b0, 16'hFF00);                          // R7 low half only
    // random, biased toward few asserted lines
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] d;
      logic ei;
      d  = 16'($urandom) | 16'($urandom) | ((n % 3 == 0) ? 16'h0 : 16'($urandom));
      ei = ($urandom % 8) == 0;
      checkChain(ei, d);
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule